// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a simple host port and a synchronous DRAM. It turns each host request (address plus direction) into the command cycles the memory needs: it opens the row, issues a read or write with auto-precharge, and then holds off until the bank's row cycle has finished. It drives chip select, row strobe, column strobe, write enable, two bank bits and an 11-bit address bus. It also drives clock enable. Every timing gap is a parameter counted in clocks.

After reset the block powers the memory up without help from the host. It waits, precharges all banks, runs two refreshes and programs the mode word. From then on an interval counter raises a refresh request at a fixed rate. A waiting refresh is served before any new host access, once the access in flight has finished. Each access closes its row, so all banks are idle whenever a refresh is issued.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: mode set 0000, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, no-op 0111. A no-op appears in every cycle without a command and throughout reset. Clock enable is low during reset.
- R2: At power-up the first command comes no earlier than INIT_WAIT cycles after reset is released. It is a precharge with address bit 10 high (all banks). Two refreshes and then a mode set follow. No activate, read or write appears before the mode set.
- R3: The mode set puts its fields on the address bus and drives bank bits 0. Bits 2:0 carry BURST_CODE, bit 3 carries BURST_INTERLEAVE, bits 6:4 carry CAS_CODE and bit 9 carries SINGLE_WRITE. All other address bits are zero.
- R4: After a mode set, no other command appears for fewer than TMRD cycles.
- R5: An activate drives sd_ba = host_addr[20:19] and sd_addr = host_addr[18:8] (the row). The matching read or write follows exactly TRCD cycles later.
- R6: The column command is a write when host_wr is 1 and a read when it is 0. It carries address bit 10 high (auto-precharge), bits 9:8 zero, bits 7:0 equal to host_addr[7:0], and the same bank as the activate.
- R7: host_ack is high for one cycle, exactly in the cycle the read or write command appears, and at no other time.
- R8: Minimum gaps between commands:
  - a refresh comes at least TRP cycles after a precharge;
  - an activate, refresh or mode set comes at least TRC cycles after a refresh;
  - an activate or refresh comes at least TRC cycles after an activate;
  - an activate or refresh comes at least POST = max(TRC−TRCD, TRAS+TRP−TRCD) cycles after a read or write.
- R9: A pending refresh wins over a waiting host request. Under continuous requests, successive refreshes are therefore never more than REF_INTERVAL+TRCD+POST+2 cycles apart. The first refresh is measured from the mode set.
- R10: A refresh is issued only when clock enable is high in both that cycle and the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | {bank[1:0], row[10:0], column[7:0]} |
| host_ack | output | 1 | One-cycle acknowledge, aligned with the column command |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 11 | Row, column or mode word; bit 10 is the all-banks / auto-precharge flag |

## Verification
The refresh interval counter and the host port can both want the idle slot in the same cycle. The bench provokes this by keeping a request waiting without a break through a long sweep over banks, directions, rows and columns, so that every refresh interval expires while a request is queued. The clash is judged in two ways. First, the spacing between successive refreshes must stay within the bound. Second, the access that was held back must still appear afterwards with its correct bank, row, column and gaps, and with exactly one acknowledge.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] OP_MODE = 4'b0000;
    localparam logic [3:0] OP_ACT  = 4'b0011;
    localparam logic [3:0] OP_RD   = 4'b0101;
    localparam logic [3:0] OP_WR   = 4'b0100;
    localparam logic [3:0] OP_PRE  = 4'b0010;
    localparam logic [3:0] OP_REF  = 4'b0001;
    localparam logic [3:0] OP_NOP  = 4'b0111;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } host_addr_t;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_PREALL,
        ST_INITREF,
        ST_MODESET,
        ST_IDLE,
        ST_COLUMN
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [ROW_W-1:0] build_mode(input logic [2:0] bl,
                                                    input logic       bt,
                                                    input logic [2:0] cl,
                                                    input logic       wm);
        logic [ROW_W-1:0] w;
        w      = '0;
        w[2:0] = bl;
        w[3]   = bt;
        w[6:4] = cl;
        w[9]   = wm;
        return w;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int TW        = 16,
    parameter int RESET_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TW'(RESET_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic clear,
    output logic pending
);

    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (enable && wrap) begin
            pending <= 1'b1;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
    import sdram_seq_pkg::*;
#(
    parameter int               TRCD      = 3,
    parameter int               TRP       = 3,
    parameter int               TRC       = 9,
    parameter int               TRAS      = 6,
    parameter int               TMRD      = 2,
    parameter int               INIT_REFS = 2,
    parameter int               TW        = 16,
    parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  host_addr_t        req_addr,
    input  logic              ref_pending,
    input  logic              gap_expired,
    output logic              gap_load,
    output logic [TW-1:0]     gap_val,
    output logic              ref_issue,
    output logic              run_en,
    output logic              cke_o,
    output logic [3:0]        op_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              ack_o
);

    localparam int POST = imax(TRC - TRCD, TRAS + TRP - TRCD);
    localparam int RC_W = $clog2(INIT_REFS + 1);

    // the gap timer is loaded with (gap - 2): one cycle to expire, one to issue
    localparam logic [TW-1:0] L_RCD  = TW'(TRCD - 2);
    localparam logic [TW-1:0] L_RP   = TW'(TRP - 2);
    localparam logic [TW-1:0] L_RC   = TW'(TRC - 2);
    localparam logic [TW-1:0] L_MRD  = TW'(TMRD - 2);
    localparam logic [TW-1:0] L_POST = TW'(POST - 2);

    seq_state_e        state_q, state_d;
    seq_state_e        tgt_q, tgt_d;
    logic [RC_W-1:0]   refs_q, refs_d;
    host_addr_t        lat_q, lat_d;
    logic              latwr_q, latwr_d;
    logic              run_q, run_d;
    logic [3:0]        op_d;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  addr_d;
    logic              ack_d;

    always_comb begin
        state_d   = state_q;
        tgt_d     = tgt_q;
        refs_d    = refs_q;
        lat_d     = lat_q;
        latwr_d   = latwr_q;
        run_d     = run_q;
        op_d      = OP_NOP;
        ba_d      = '0;
        addr_d    = '0;
        ack_d     = 1'b0;
        gap_load  = 1'b0;
        gap_val   = '0;
        ref_issue = 1'b0;

        unique case (state_q)
            ST_GAP: begin
                if (gap_expired) begin
                    state_d = tgt_q;
                end
            end
            ST_PREALL: begin
                op_d           = OP_PRE;
                addr_d[AP_BIT] = 1'b1;
                gap_load       = 1'b1;
                gap_val        = L_RP;
                tgt_d          = ST_INITREF;
                state_d        = ST_GAP;
            end
            ST_INITREF: begin
                op_d     = OP_REF;
                gap_load = 1'b1;
                gap_val  = L_RC;
                refs_d   = refs_q + 1'b1;
                tgt_d    = (refs_q == RC_W'(INIT_REFS - 1)) ? ST_MODESET : ST_INITREF;
                state_d  = ST_GAP;
            end
            ST_MODESET: begin
                op_d     = OP_MODE;
                addr_d   = MODE_WORD;
                gap_load = 1'b1;
                gap_val  = L_MRD;
                run_d    = 1'b1;
                tgt_d    = ST_IDLE;
                state_d  = ST_GAP;
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    op_d      = OP_REF;
                    ref_issue = 1'b1;
                    gap_load  = 1'b1;
                    gap_val   = L_RC;
                    tgt_d     = ST_IDLE;
                    state_d   = ST_GAP;
                end else if (req) begin
                    op_d     = OP_ACT;
                    ba_d     = req_addr.bank;
                    addr_d   = req_addr.row;
                    lat_d    = req_addr;
                    latwr_d  = req_wr;
                    gap_load = 1'b1;
                    gap_val  = L_RCD;
                    tgt_d    = ST_COLUMN;
                    state_d  = ST_GAP;
                end
            end
            ST_COLUMN: begin
                op_d               = latwr_q ? OP_WR : OP_RD;
                ba_d               = lat_q.bank;
                addr_d[COL_W-1:0]  = lat_q.col;
                addr_d[AP_BIT]     = 1'b1;
                ack_d              = 1'b1;
                gap_load           = 1'b1;
                gap_val            = L_POST;
                tgt_d              = ST_IDLE;
                state_d            = ST_GAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GAP;
            tgt_q   <= ST_PREALL;
            refs_q  <= '0;
            lat_q   <= '0;
            latwr_q <= 1'b0;
            run_q   <= 1'b0;
            cke_o   <= 1'b0;
            op_o    <= OP_NOP;
            ba_o    <= '0;
            addr_o  <= '0;
            ack_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            refs_q  <= refs_d;
            lat_q   <= lat_d;
            latwr_q <= latwr_d;
            run_q   <= run_d;
            cke_o   <= 1'b1;
            op_o    <= op_d;
            ba_o    <= ba_d;
            addr_o  <= addr_d;
            ack_o   <= ack_d;
        end
    end

    assign run_en = run_q;

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int         INIT_WAIT        = 25000,
    parameter int         REF_INTERVAL     = 1950,
    parameter int         TRCD             = 3,
    parameter int         TRP              = 3,
    parameter int         TRC              = 9,
    parameter int         TRAS             = 6,
    parameter int         TMRD             = 2,
    parameter logic [2:0] BURST_CODE       = 3'd2,
    parameter logic       BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0] CAS_CODE         = 3'd3,
    parameter logic       SINGLE_WRITE     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ack,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr
);

    localparam int POST    = imax(TRC - TRCD, TRAS + TRP - TRCD);
    localparam int MAX_GAP = imax(INIT_WAIT, imax(TRC, imax(POST, imax(TRP, TMRD))));
    localparam int TW      = $clog2(MAX_GAP + 1) + 1;
    localparam logic [ROW_W-1:0] MODE_WORD =
        build_mode(BURST_CODE, BURST_INTERLEAVE, CAS_CODE, SINGLE_WRITE);

    logic          gap_load;
    logic [TW-1:0] gap_val;
    logic          gap_expired;
    logic          ref_pending;
    logic          ref_issue;
    logic          run_en;
    logic [3:0]    op;
    host_addr_t    req_addr;

    assign req_addr = host_addr_t'(host_addr);

    sdram_gap_timer #(
        .TW        (TW),
        .RESET_VAL (INIT_WAIT - 1)
    ) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    sdram_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .enable  (run_en),
        .clear   (ref_issue),
        .pending (ref_pending)
    );

    sdram_cmd_fsm #(
        .TRCD      (TRCD),
        .TRP       (TRP),
        .TRC       (TRC),
        .TRAS      (TRAS),
        .TMRD      (TMRD),
        .INIT_REFS (2),
        .TW        (TW),
        .MODE_WORD (MODE_WORD)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (host_req),
        .req_wr      (host_wr),
        .req_addr    (req_addr),
        .ref_pending (ref_pending),
        .gap_expired (gap_expired),
        .gap_load    (gap_load),
        .gap_val     (gap_val),
        .ref_issue   (ref_issue),
        .run_en      (run_en),
        .cke_o       (sd_cke),
        .op_o        (op),
        .ba_o        (sd_ba),
        .addr_o      (sd_addr),
        .ack_o       (host_ack)
    );

    assign sd_cs_n  = op[3];
    assign sd_ras_n = op[2];
    assign sd_cas_n = op[1];
    assign sd_we_n  = op[0];

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int         REF_INTERVAL     = 1950,
    parameter int         TRCD             = 3,
    parameter int         TRP              = 3,
    parameter int         TRC              = 9,
    parameter int         TRAS             = 6,
    parameter int         TMRD             = 2,
    parameter logic [2:0] BURST_CODE       = 3'd2,
    parameter logic       BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0] CAS_CODE         = 3'd3,
    parameter logic       SINGLE_WRITE     = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ack,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_addr
);

    localparam int POST  = imax(TRC - TRCD, TRAS + TRP - TRCD);
    localparam int BOUND = REF_INTERVAL + TRCD + POST + 2;
    localparam int CW    = $clog2(BOUND + 4) + 2;
    localparam logic [CW-1:0] SAT = '1;

    logic [3:0] op;
    logic is_act, is_ref, is_rw, is_pre, is_mrs, is_nop;
    logic [CW-1:0] s_act, s_ref, s_rw, s_pre, s_mrs, s_due;
    logic running;
    logic [ROW_W-1:0] mode_exp;

    assign op     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (op == OP_ACT);
    assign is_ref = (op == OP_REF);
    assign is_rw  = (op == OP_RD) || (op == OP_WR);
    assign is_pre = (op == OP_PRE);
    assign is_mrs = (op == OP_MODE);
    assign is_nop = (op == OP_NOP);

    always_comb begin
        mode_exp = '0;
        mode_exp = mode_exp | ROW_W'(BURST_CODE);
        mode_exp = mode_exp | (ROW_W'(BURST_INTERLEAVE) << 3);
        mode_exp = mode_exp | (ROW_W'(CAS_CODE) << 4);
        mode_exp = mode_exp | (ROW_W'(SINGLE_WRITE) << 9);
    end

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
        return (v == SAT) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            s_act   <= SAT;
            s_ref   <= SAT;
            s_rw    <= SAT;
            s_pre   <= SAT;
            s_mrs   <= SAT;
            s_due   <= '0;
            running <= 1'b0;
        end else begin
            s_act <= is_act ? CW'(1) : bump(s_act);
            s_ref <= is_ref ? CW'(1) : bump(s_ref);
            s_rw  <= is_rw  ? CW'(1) : bump(s_rw);
            s_pre <= is_pre ? CW'(1) : bump(s_pre);
            s_mrs <= is_mrs ? CW'(1) : bump(s_mrs);
            s_due <= (is_ref || is_mrs) ? CW'(1) : bump(s_due);
            if (is_mrs) running <= 1'b1;
        end
    end

    assert_legal_op_R1: assert property (@(posedge clk) disable iff (rst)
        (is_nop || is_act || is_rw || is_pre || is_mrs || is_ref));

    assert_mode_word_R3: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (sd_addr == mode_exp) && (sd_ba == '0));

    assert_mode_gap_R4: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> (s_mrs >= CW'(TMRD)));

    assert_act_to_col_R5: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> (s_act == CW'(TRCD)));

    assert_autoprecharge_R6: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> sd_addr[AP_BIT] && (sd_addr[9:8] == 2'b00));

    assert_ack_on_col_R7: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> is_rw);

    assert_col_has_ack_R7: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> host_ack);

    assert_pre_to_ref_R8: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (s_pre >= CW'(TRP)));

    assert_row_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (is_act || is_ref) |-> (s_act >= CW'(TRC)) && (s_rw >= CW'(POST)));

    assert_after_ref_R8: assert property (@(posedge clk) disable iff (rst)
        (is_act || is_ref || is_mrs) |-> (s_ref >= CW'(TRC)));

    assert_refresh_bound_R9: assert property (@(posedge clk) disable iff (rst)
        running |-> (s_due <= CW'(BOUND)));

    assert_ref_cke_R10: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> sd_cke && $past(sd_cke));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .REF_INTERVAL     (REF_INTERVAL),
    .TRCD             (TRCD),
    .TRP              (TRP),
    .TRC              (TRC),
    .TRAS             (TRAS),
    .TMRD             (TMRD),
    .BURST_CODE       (BURST_CODE),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_CODE         (CAS_CODE),
    .SINGLE_WRITE     (SINGLE_WRITE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_ack (host_ack),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

    localparam int INIT_WAIT    = 40;
    localparam int REF_INTERVAL = 150;
    localparam int TRCD = 3;
    localparam int TRP  = 3;
    localparam int TRC  = 9;
    localparam int TRAS = 6;
    localparam int TMRD = 2;
    localparam int POST = ((TRC - TRCD) > (TRAS + TRP - TRCD)) ? (TRC - TRCD) : (TRAS + TRP - TRCD);
    localparam int REF_BOUND = REF_INTERVAL + TRCD + POST + 2;
    localparam int BL = 2, BT = 0, CL = 3, WM = 1;
    localparam int MODE_EXP = BL + BT * 8 + CL * 16 + WM * 512;
    localparam int N_ACC = 4 * 2 * 4 * 3;

    localparam int C_MODE = 0, C_ACT = 3, C_RD = 5, C_WR = 4, C_PRE = 2, C_REF = 1, C_NOP = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [20:0] host_addr = '0;
    logic        host_ack;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [10:0] sd_addr;

    int checked = 0;
    int failed  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    sdram_cmd_seq #(
        .INIT_WAIT        (INIT_WAIT),
        .REF_INTERVAL     (REF_INTERVAL),
        .TRCD             (TRCD),
        .TRP              (TRP),
        .TRC              (TRC),
        .TRAS             (TRAS),
        .TMRD             (TMRD),
        .BURST_CODE       (3'(BL)),
        .BURST_INTERLEAVE (1'(BT)),
        .CAS_CODE         (3'(CL)),
        .SINGLE_WRITE     (1'(WM))
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_ack  (host_ack),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checked++;
        if (!ok) begin
            failed++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst) cyc <= cyc + 1;
    end

    // command monitor
    int  init_step = 0;
    int  last_act = -100000, last_ref = -100000, last_rw = -100000;
    int  last_pre = -100000, last_mrs = -100000, last_due = 0;
    int  ref_run = 0;
    int  exp_bank = 0, exp_col = 0, exp_wr = 0;
    bit  prev_cke = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            int op;
            op = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (host_ack && op != C_RD && op != C_WR) check(1'b0, "R7 ack without column command", op, C_RD);
            if (op == C_PRE) begin
                check(init_step == 0, "R2 precharge order", init_step, 0);
                check(cyc >= INIT_WAIT, "R2 power-up wait", cyc, INIT_WAIT);
                check(sd_addr[10] == 1'b1, "R2 precharge-all flag", sd_addr[10], 1);
                init_step = 1;
                last_pre  = cyc;
            end else if (op == C_REF) begin
                check(sd_cke && prev_cke, "R10 clock enable at refresh", {prev_cke, sd_cke}, 3);
                check(cyc - last_pre >= TRP, "R8 precharge to refresh", cyc - last_pre, TRP);
                check(cyc - last_ref >= TRC && cyc - last_act >= TRC && cyc - last_rw >= POST,
                      "R8 refresh spacing", cyc - last_ref, TRC);
                if (init_step == 1 || init_step == 2) begin
                    init_step++;
                end else begin
                    check(init_step == 4, "R2 refresh order", init_step, 4);
                    check(cyc - last_due <= REF_BOUND, "R9 refresh interval", cyc - last_due, REF_BOUND);
                    ref_run++;
                end
                last_ref = cyc;
                last_due = cyc;
            end else if (op == C_MODE) begin
                check(init_step == 3, "R2 mode set order", init_step, 3);
                check(cyc - last_ref >= TRC, "R8 refresh to mode set", cyc - last_ref, TRC);
                check(sd_addr == 11'(MODE_EXP) && sd_ba == 2'd0, "R3 mode word", sd_addr, MODE_EXP);
                init_step = 4;
                last_mrs  = cyc;
                last_due  = cyc;
            end else if (op == C_ACT) begin
                check(init_step == 4, "R2 activate before mode set", init_step, 4);
                check(cyc - last_mrs >= TMRD, "R4 mode set gap", cyc - last_mrs, TMRD);
                check(cyc - last_act >= TRC && cyc - last_ref >= TRC, "R8 row cycle", cyc - last_act, TRC);
                check(cyc - last_rw >= POST, "R8 column to activate", cyc - last_rw, POST);
                check(sd_ba == host_addr[20:19], "R5 activate bank", sd_ba, host_addr[20:19]);
                check(sd_addr == host_addr[18:8], "R5 activate row", sd_addr, host_addr[18:8]);
                exp_bank = int'(host_addr[20:19]);
                exp_col  = int'(host_addr[7:0]);
                exp_wr   = int'(host_wr);
                last_act = cyc;
            end else if (op == C_RD || op == C_WR) begin
                check(init_step == 4, "R2 column before mode set", init_step, 4);
                check(cyc - last_act == TRCD, "R5 activate to column", cyc - last_act, TRCD);
                check(op == (exp_wr != 0 ? C_WR : C_RD), "R6 direction", op, exp_wr != 0 ? C_WR : C_RD);
                check(sd_addr[10] == 1'b1 && sd_addr[9:8] == 2'b00, "R6 auto-precharge flag",
                      sd_addr[10:8], 4);
                check(int'(sd_addr[7:0]) == exp_col, "R6 column", sd_addr[7:0], exp_col);
                check(int'(sd_ba) == exp_bank, "R6 bank", sd_ba, exp_bank);
                check(host_ack == 1'b1, "R7 ack with column", host_ack, 1);
                last_rw = cyc;
            end else if (op != C_NOP) begin
                check(1'b0, "R1 illegal command code", op, C_NOP);
            end
            prev_cke = sd_cke;
        end
    end

    // stimulus
    int acks = 0;

    initial begin
        repeat (3) @(negedge clk);
        check(sd_cke == 1'b0, "R1 clock enable in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'(C_NOP), "R1 no-op in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(host_ack == 1'b0, "R7 ack in reset", host_ack, 0);
        rst = 1'b0;
        // first request waits through power-up
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int r = 0; r < 4; r++) begin
                    for (int c = 0; c < 3; c++) begin
                        int row, col;
                        row = (r * 683 + b * 5) % 2048;
                        col = (c * 85 + b * 17 + w) % 256;
                        host_addr = 21'(b * 524288 + row * 256 + col);
                        host_wr   = 1'(w);
                        host_req  = 1'b1;
                        do @(negedge clk); while (!host_ack);
                        acks++;
                    end
                end
            end
        end
        host_req = 1'b0;
        repeat (3 * REF_INTERVAL) @(negedge clk);
        check(acks == N_ACC, "R7 acknowledge count", acks, N_ACC);
        check(ref_run >= (cyc - last_mrs) / REF_BOUND, "R9 refresh count", ref_run,
              (cyc - last_mrs) / REF_BOUND);
        check(init_step == 4, "R2 power-up completed", init_step, 4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checked++;
        failed++;
        $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d acks", acks, N_ACC);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end

endmodule